// File: doc/BRIEF.md
# Retry-Counting Power Fault Supervisor

This block decides how a multi-rail power controller reacts when one of its outputs misbehaves. It watches digital flags from analog comparators: overvoltage and overcurrent on the switching core rail (rail 1), undervoltage on three linear rails (2, 3 and 4), two soft-start ramp "fully charged" flags, a "first ramp below restart level" flag, an all-rails-good flag and a bias-present flag. From these it drives the rail 1–3 inhibit, discharge requests for the two soft-start ramps, a low-side clamp request and a latched fault output.

The response depends on which rail faulted. Core overvoltage and rail 4 undervoltage shut the controller down for good. A core overcurrent, or an undervoltage on rail 2 or rail 3, starts a retry. The rails are inhibited, the second ramp is dumped at once, and the first ramp finishes charging before it is discharged. The retry ends when the first ramp has fallen below its restart level. Overcurrent events and linear-rail undervoltage events are counted separately. The third event on either counter latches the controller off. A clean start-up clears both counters. Loss of bias clears all state.

The first ramp group contains rails 2 and 4. The second ramp group contains rails 1 and 3. Every output is registered, so an output responds one clock after the input that caused it.

Top module: `fault_supervisor`

## Requirements
- R1: When `core_ov` is high with bias present, one cycle later `fault_latched`, `lowside_on`, `inhibit`, `discharge_a` and `discharge_b` are all 1.
- R2: When `uv_rail4` and `ramp_a_full` are both high, one cycle later `fault_latched`, `inhibit`, `discharge_a` and `discharge_b` are 1 and `lowside_on` is 0. When `ramp_a_full` is low, `uv_rail4` has no effect.
- R3: While the block is idle (no latched fault, no retry running), a qualified retry fault starts a retry. A qualified retry fault is `core_oc`, or `uv_rail2` qualified by R5, or `uv_rail3` qualified by R5. One cycle later `inhibit` and `discharge_b` are 1, while `discharge_a` and `fault_latched` are 0.
- R4: During a retry, `discharge_a` stays 0 until the cycle after `ramp_a_full` is seen. It then stays 1 until `ramp_a_low` is seen. One cycle after that, `inhibit`, `discharge_a` and `discharge_b` all return to 0.
- R5: `uv_rail2` is ignored unless `ramp_a_full` is high in the same cycle. `uv_rail3` is ignored unless `ramp_b_full` is high in the same cycle.
- R6: Overcurrent events and linear undervoltage events have separate counters, each saturating at 3. The third event on one counter sets `fault_latched` instead of starting a retry. Two events on each counter do not latch.
- R7: When `all_good` is high while the block is idle and no fault flag is active, both counters return to zero.
- R8: When `bias_ok` is low, one cycle later every output is 0 and both counters are clear.
- R9: Once `fault_latched` is set, it and its outputs hold while bias stays present, whatever the other inputs do.
- R10: If a latch-off fault (R1, R2) and a retry fault arrive in the same cycle, the latch-off response is taken and no retry starts.
- R11: After reset, every output is 0.
- R12: Retry faults that arrive while a retry is running are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_ov | input | 1 | Core rail overvoltage flag |
| core_oc | input | 1 | Core rail overcurrent flag |
| uv_rail2 | input | 1 | Rail 2 undervoltage flag |
| uv_rail3 | input | 1 | Rail 3 undervoltage flag |
| uv_rail4 | input | 1 | Rail 4 undervoltage flag |
| ramp_a_full | input | 1 | First soft-start ramp fully charged |
| ramp_b_full | input | 1 | Second soft-start ramp fully charged |
| ramp_a_low | input | 1 | First ramp below restart level |
| all_good | input | 1 | All rails within good limits |
| bias_ok | input | 1 | Bias power present |
| inhibit | output | 1 | Inhibit rails 1 to 3 |
| discharge_a | output | 1 | Discharge request, first ramp |
| discharge_b | output | 1 | Discharge request, second ramp |
| lowside_on | output | 1 | Hold core low-side switch on |
| fault_latched | output | 1 | Permanent fault latch state |

## Verification
A latch-off fault and a retry fault can arrive in the same cycle. The bench provokes this by sweeping every combination of the five fault flags and the two ramp-full flags. Each combination starts from a freshly cleared state. The bench computes the expected inhibit, discharge, clamp and latch values from the blanking and priority rules, so a same-cycle clash must show the latch-off pattern and never the retry pattern. The third-event boundary is covered by stepping each counter separately through complete retries, with counter clears placed between the steps.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_WAIT  = 2'd1,
    RS_DRAIN = 2'd2
  } rs_state_e;

  localparam int NUM_CNT = 2;
  localparam int CNT_OC  = 0;
  localparam int CNT_UV  = 1;
endpackage

// File: rtl/fs_sat_counter.sv
module fs_sat_counter #(
  parameter int W   = 2,
  parameter int MAX = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CAP = W'(MAX);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = clr | inc;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && (cnt_q != CAP)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/fs_restart_ctl.sv
module fs_restart_ctl
  import fs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  input  logic ramp_full,
  input  logic ramp_low,
  output logic active,
  output logic drain
);
  rs_state_e st_q;
  rs_state_e st_d;

  always_comb begin
    st_d = st_q;
    if (clr) begin
      st_d = RS_IDLE;
    end else begin
      case (st_q)
        RS_IDLE:  if (start)     st_d = RS_WAIT;
        RS_WAIT:  if (ramp_full) st_d = RS_DRAIN;
        RS_DRAIN: if (ramp_low)  st_d = RS_IDLE;
        default:                 st_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RS_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign active = (st_q != RS_IDLE);
  assign drain  = (st_q == RS_DRAIN);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fs_pkg::*;
#(
  parameter int CNT_W       = 2,
  parameter int RETRY_LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_ov,
  input  logic core_oc,
  input  logic uv_rail2,
  input  logic uv_rail3,
  input  logic uv_rail4,
  input  logic ramp_a_full,
  input  logic ramp_b_full,
  input  logic ramp_a_low,
  input  logic all_good,
  input  logic bias_ok,
  output logic inhibit,
  output logic discharge_a,
  output logic discharge_b,
  output logic lowside_on,
  output logic fault_latched
);
  localparam logic [CNT_W-1:0] LAST_RETRY = CNT_W'(RETRY_LIMIT - 1);

  // qualified fault flags
  logic uv2_q, uv3_q, uv4_q;
  logic hard_evt, armed, oc_evt, uv_evt, any_evt, limit_hit;
  logic rs_start, rs_clr, rs_active, rs_drain;
  logic fault_q, fault_d, ov_q, ov_d;
  logic [NUM_CNT-1:0] cnt_inc, cnt_clr;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];

  assign uv2_q    = uv_rail2 & ramp_a_full;
  assign uv3_q    = uv_rail3 & ramp_b_full;
  assign uv4_q    = uv_rail4 & ramp_a_full;
  assign hard_evt = core_ov | uv4_q;
  assign armed    = bias_ok & ~fault_q & ~rs_active;
  assign oc_evt   = armed & core_oc;
  assign uv_evt   = armed & (uv2_q | uv3_q);
  assign any_evt  = oc_evt | uv_evt | hard_evt;

  assign limit_hit = (oc_evt & (cnt_val[CNT_OC] == LAST_RETRY)) |
                     (uv_evt & (cnt_val[CNT_UV] == LAST_RETRY));

  // latch-off outranks retry
  assign rs_start = (oc_evt | uv_evt) & ~hard_evt & ~limit_hit;

  assign cnt_inc[CNT_OC] = oc_evt & ~hard_evt;
  assign cnt_inc[CNT_UV] = uv_evt & ~hard_evt;

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      assign cnt_clr[g] = ~bias_ok | (all_good & armed & ~any_evt);
      fs_sat_counter #(
        .W   (CNT_W),
        .MAX (RETRY_LIMIT)
      ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr[g]),
        .inc   (cnt_inc[g]),
        .count (cnt_val[g])
      );
    end
  endgenerate

  always_comb begin
    fault_d = fault_q;
    ov_d    = ov_q;
    if (!bias_ok) begin
      fault_d = 1'b0;
      ov_d    = 1'b0;
    end else begin
      if (hard_evt || limit_hit) fault_d = 1'b1;
      if (core_ov)               ov_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      ov_q    <= 1'b0;
    end else begin
      fault_q <= fault_d;
      ov_q    <= ov_d;
    end
  end

  assign rs_clr = ~bias_ok | fault_d;

  fs_restart_ctl u_restart (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rs_clr),
    .start     (rs_start),
    .ramp_full (ramp_a_full),
    .ramp_low  (ramp_a_low),
    .active    (rs_active),
    .drain     (rs_drain)
  );

  assign inhibit       = fault_q | rs_active;
  assign discharge_a   = fault_q | rs_drain;
  assign discharge_b   = fault_q | rs_active;
  assign lowside_on    = ov_q;
  assign fault_latched = fault_q;
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic core_ov,
  input logic core_oc,
  input logic uv_rail2,
  input logic uv_rail3,
  input logic uv_rail4,
  input logic ramp_a_full,
  input logic ramp_b_full,
  input logic bias_ok,
  input logic inhibit,
  input logic discharge_a,
  input logic discharge_b,
  input logic lowside_on,
  input logic fault_latched
);
  AST_OV_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ov && bias_ok) |=> (fault_latched && lowside_on && inhibit)); // R1

  AST_UV4_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_rail4 && ramp_a_full && bias_ok) |=> fault_latched); // R2

  AST_RETRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(inhibit) && !fault_latched) |->
      $past(core_oc || (uv_rail2 && ramp_a_full) || (uv_rail3 && ramp_b_full))); // R3

  AST_DRAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    discharge_a |-> (inhibit && discharge_b)); // R4

  AST_BIAS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_ok |=> (!fault_latched && !inhibit && !lowside_on)); // R8

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && bias_ok) |=> fault_latched); // R9
endmodule

bind fault_supervisor fault_supervisor_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_ov       (core_ov),
  .core_oc       (core_oc),
  .uv_rail2      (uv_rail2),
  .uv_rail3      (uv_rail3),
  .uv_rail4      (uv_rail4),
  .ramp_a_full   (ramp_a_full),
  .ramp_b_full   (ramp_b_full),
  .bias_ok       (bias_ok),
  .inhibit       (inhibit),
  .discharge_a   (discharge_a),
  .discharge_b   (discharge_b),
  .lowside_on    (lowside_on),
  .fault_latched (fault_latched)
);

// File: tb/tb_fault_supervisor.sv
`timescale 1ns/1ps
module tb_fault_supervisor;
  logic clk = 1'b0;
  logic rst_n;
  logic core_ov, core_oc, uv_rail2, uv_rail3, uv_rail4;
  logic ramp_a_full, ramp_b_full, ramp_a_low, all_good, bias_ok;
  logic inhibit, discharge_a, discharge_b, lowside_on, fault_latched;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // output vector order: {fault_latched, lowside_on, inhibit, discharge_a, discharge_b}
  localparam logic [4:0] O_IDLE  = 5'b00000;
  localparam logic [4:0] O_RETRY = 5'b00101;
  localparam logic [4:0] O_DRAIN = 5'b00111;
  localparam logic [4:0] O_LATCH = 5'b10111;

  always #2.5 clk = ~clk;

  fault_supervisor dut (
    .clk (clk), .rst_n (rst_n),
    .core_ov (core_ov), .core_oc (core_oc),
    .uv_rail2 (uv_rail2), .uv_rail3 (uv_rail3), .uv_rail4 (uv_rail4),
    .ramp_a_full (ramp_a_full), .ramp_b_full (ramp_b_full),
    .ramp_a_low (ramp_a_low), .all_good (all_good), .bias_ok (bias_ok),
    .inhibit (inhibit), .discharge_a (discharge_a), .discharge_b (discharge_b),
    .lowside_on (lowside_on), .fault_latched (fault_latched)
  );

  function automatic logic [4:0] outs();
    return {fault_latched, lowside_on, inhibit, discharge_a, discharge_b};
  endfunction

  task automatic chk(input string req, input logic [4:0] exp);
    checks++;
    if (outs() !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, outs(), exp, $time);
    end
  endtask

  task automatic quiet();
    core_ov = 0; core_oc = 0; uv_rail2 = 0; uv_rail3 = 0; uv_rail4 = 0;
    ramp_a_full = 0; ramp_b_full = 0; ramp_a_low = 0; all_good = 0;
  endtask

  task automatic bias_cycle();
    quiet();
    bias_ok = 0;
    @(negedge clk);
    bias_ok = 1;
  endtask

  // kind 0: overcurrent, 1: rail 2 UV, 2: rail 3 UV
  task automatic retry(input int kind, input bit extra_oc);
    case (kind)
      0: core_oc = 1;
      1: begin uv_rail2 = 1; ramp_a_full = 1; end
      default: begin uv_rail3 = 1; ramp_b_full = 1; end
    endcase
    @(negedge clk);
    chk("R3 retry start", O_RETRY);
    quiet();
    core_oc = extra_oc;
    @(negedge clk);
    chk("R4 wait for full", O_RETRY);
    quiet();
    ramp_a_full = 1;
    @(negedge clk);
    chk("R4 drain after full", O_DRAIN);
    ramp_a_full = 0;
    @(negedge clk);
    chk("R4 drain held", O_DRAIN);
    ramp_a_low = 1;
    @(negedge clk);
    chk("R4 retry end", O_IDLE);
    ramp_a_low = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    quiet();
    bias_ok = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R11 reset", O_IDLE);
    @(negedge clk);
    chk("R11 idle after reset", O_IDLE);

    // R1 R2 R3 R5 R10: sweep of fault flags and ramp-full flags
    for (int v = 0; v < 128; v++) begin
      logic ov, oc, u2, u3, u4, fa, fb, q2, q3, q4, hard, rs;
      logic [4:0] exp;
      bias_cycle();
      {ov, oc, u2, u3, u4, fa, fb} = 7'(v);
      core_ov = ov; core_oc = oc; uv_rail2 = u2; uv_rail3 = u3; uv_rail4 = u4;
      ramp_a_full = fa; ramp_b_full = fb;
      q2 = u2 & fa; q3 = u3 & fb; q4 = u4 & fa;
      hard = ov | q4;
      rs = ~hard & (oc | q2 | q3);
      exp = {hard, ov, hard | rs, hard, hard | rs};
      @(negedge clk);
      chk("R1/R2/R3/R5/R10 sweep", exp);
    end

    // R6: third overcurrent latches
    bias_cycle();
    retry(0, 0);
    retry(0, 0);
    core_oc = 1;
    @(negedge clk);
    chk("R6 third OC latches", O_LATCH);
    // R9: latched state holds
    quiet();
    core_oc = 1; ramp_a_low = 1; all_good = 1; uv_rail2 = 1;
    repeat (3) @(negedge clk);
    chk("R9 latch held", O_LATCH);
    // R8: bias removal clears
    quiet();
    bias_ok = 0;
    @(negedge clk);
    chk("R8 bias clear", O_IDLE);
    bias_ok = 1;

    // R6: third UV latches, counters separate
    retry(0, 0);
    retry(0, 0);
    retry(1, 0);
    retry(2, 0);
    chk("R6 two each no latch", O_IDLE);
    uv_rail3 = 1; ramp_b_full = 1;
    @(negedge clk);
    chk("R6 third UV latches", O_LATCH);

    // R7: good start-up clears counters
    bias_cycle();
    retry(0, 0);
    retry(0, 0);
    all_good = 1;
    @(negedge clk);
    chk("R7 all good idle", O_IDLE);
    all_good = 0;
    retry(0, 0);
    retry(0, 0);
    chk("R7 counters were cleared", O_IDLE);
    core_oc = 1;
    @(negedge clk);
    chk("R7 third after clear latches", O_LATCH);

    // R12: fault during retry not counted
    bias_cycle();
    retry(0, 1);
    retry(0, 0);
    chk("R12 ignored event not counted", O_IDLE);
    core_oc = 1;
    @(negedge clk);
    chk("R12 third real event latches", O_LATCH);

    // R8 after OV clamp
    bias_cycle();
    core_ov = 1;
    @(negedge clk);
    chk("R1 OV clamp", 5'b11111);
    quiet();
    bias_ok = 0;
    @(negedge clk);
    chk("R8 clamp cleared", O_IDLE);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule